// File: doc/BRIEF.md
# Four-Channel Converter Alarm and Configuration Registers

This block keeps the per-channel setup and alarm state of a four-input analog converter. Every channel owns two control/status bytes and a pair of 8-bit alarm limits. All of them sit in a small byte-addressed space with a simple write strobe and a registered read port. When the converter finishes a sample it pulses a strobe with the channel number and a left-aligned 16-bit result. The block then recomputes that channel's over-limit and under-limit flags.

The block drives two kinds of output. The first is one open-drain sink control per channel, for channels used as digital outputs. The second is a single flag that tells the enumeration logic to answer a conditional search. That flag stays raised while a device-wide power-up marker is set, or while any channel has an enabled alarm flag. The synchronous reset input plays the role of the power-on reset and loads every register with its default.

Top module: `chan_alarm_regs`

## Requirements
- R1: While `rst` is high at a clock edge, every register returns to its default: control byte 0 = 08h, control byte 1 = 8Ch, low limit = 00h, high limit = FFh. After that edge `csearch` is 1 and `od_sink` is 0.
- R2: Channel c (0..3) has control byte 0 at 08h+2c, control byte 1 at 09h+2c, low limit at 10h+2c and high limit at 11h+2c. `rdata` shows the byte at the `bus_addr` sampled on the previous edge. Any other address reads 00h and ignores writes.
- R3: Control byte 0 holds bit 7 = output enable, bit 6 = output level and bits 3:0 = resolution code. Bits 5:4 always read 0.
- R4: Control byte 1 holds bit 7 = power-up marker, bit 5 = over flag, bit 4 = under flag, bit 3 = over enable, bit 2 = under enable and bit 0 = range select. Bits 6 and 1 always read 0.
- R5: A conversion uses the top 8 result bits. It sets the over flag when they exceed the high limit and the under flag when they are below the low limit.
- R6: Resolution code 0 means 16 bits, and codes 1..15 mean that many bits. Below 8 bits, the unused low bits of the result and of both limits are left out of the comparison.
- R7: A conversion inside the limits clears both flags of that channel. A write of 0 to a flag bit clears it. A write of 1 to a flag bit leaves it unchanged.
- R8: A conversion and a control byte 1 write to the same channel in the same cycle set the flags from the conversion.
- R9: `csearch` is registered one cycle after the state it reflects. It is 1 when the marker is 1, or when any channel has (over flag and over enable) or (under flag and under enable).
- R10: There is one device-wide marker. The bit 7 of the latest write to any channel's control byte 1 sets it. Setting it alters no other register.
- R11: `od_sink[c]` is registered one cycle after the state. It is 1 exactly when channel c has output enable 1 and output level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data for the previous address |
| cv_valid | input | 1 | Conversion-complete strobe |
| cv_chan | input | 2 | Channel of the finished conversion |
| cv_result | input | 16 | Left-aligned conversion result |
| od_sink | output | 4 | Per-channel open-drain transistor on |
| csearch | output | 1 | Respond-to-conditional-search flag |

## Verification
A write or a conversion that is sampled at edge N changes the register contents at N. A read that shows this change must present its address after N, and `rdata` is then valid after edge N+1. `csearch` and `od_sink` follow the new state one edge later, at N+1. The bench's reference model keeps the same ordering: at each edge it produces its outputs from the state held before that edge and only then applies the inputs. It compares on the falling edge. The directed reads and output checks wait exactly those edge counts after each write or conversion task returns.

// File: rtl/chalm_pkg.sv
package chalm_pkg;
  localparam int DW       = 8;
  localparam int RCW      = 4;
  localparam int CTL_BASE = 8;
  localparam int THR_BASE = 16;

  localparam logic [DW-1:0] CTL0_DFLT = 8'h08;
  localparam logic [DW-1:0] THR_LO_DFLT = 8'h00;
  localparam logic [DW-1:0] THR_HI_DFLT = 8'hFF;

  typedef struct packed {
    logic           oe;
    logic           oc;
    logic [RCW-1:0] rc;
    logic           afh;
    logic           afl;
    logic           aeh;
    logic           ael;
    logic           ir;
    logic [DW-1:0]  lo;
    logic [DW-1:0]  hi;
  } chan_cfg_t;
endpackage

// File: rtl/chalm_thr_cmp.sv
module chalm_thr_cmp
  import chalm_pkg::*;
#(
  parameter int RW = 16
) (
  input  logic [RW-1:0]  res,
  input  logic [RCW-1:0] rc,
  input  logic [DW-1:0]  lo,
  input  logic [DW-1:0]  hi,
  output logic           over,
  output logic           under
);
  localparam int BW = $clog2(RW + 1);

  logic [BW-1:0] nbits;
  logic [DW-1:0] mask;
  logic [DW-1:0] top;
  logic          unused_low;

  // low result bits never take part in the 8-bit compare
  assign unused_low = ^res[RW-DW-1:0];

  always_comb begin
    nbits = (rc == '0) ? BW'(RW) : BW'(rc);
    mask  = (nbits >= BW'(DW)) ? {DW{1'b1}} : ~({DW{1'b1}} >> nbits);
    top   = res[RW-1 -: DW] & mask;
    over  = top > (hi & mask);
    under = top < (lo & mask);
  end
endmodule

// File: rtl/chalm_chan.sv
module chalm_chan
  import chalm_pkg::*;
#(
  parameter int RW = 16,
  parameter int AW = 5,
  parameter int CH = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          cv_hit,
  input  logic [RW-1:0] cv_result,
  output chan_cfg_t     cfg
);
  localparam logic [AW-1:0] A_CTL0 = AW'(CTL_BASE + 2*CH);
  localparam logic [AW-1:0] A_CTL1 = AW'(CTL_BASE + 2*CH + 1);
  localparam logic [AW-1:0] A_LO   = AW'(THR_BASE + 2*CH);
  localparam logic [AW-1:0] A_HI   = AW'(THR_BASE + 2*CH + 1);

  logic hit_over, hit_under;

  chalm_thr_cmp #(.RW(RW)) u_cmp (
    .res   (cv_result),
    .rc    (cfg.rc),
    .lo    (cfg.lo),
    .hi    (cfg.hi),
    .over  (hit_over),
    .under (hit_under)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.oe  <= CTL0_DFLT[7];
      cfg.oc  <= CTL0_DFLT[6];
      cfg.rc  <= CTL0_DFLT[RCW-1:0];
      cfg.afh <= 1'b0;
      cfg.afl <= 1'b0;
      cfg.aeh <= 1'b1;
      cfg.ael <= 1'b1;
      cfg.ir  <= 1'b0;
      cfg.lo  <= THR_LO_DFLT;
      cfg.hi  <= THR_HI_DFLT;
    end else begin
      if (wr && addr == A_CTL0) begin
        cfg.oe <= wdata[7];
        cfg.oc <= wdata[6];
        cfg.rc <= wdata[RCW-1:0];
      end
      if (wr && addr == A_CTL1) begin
        cfg.aeh <= wdata[3];
        cfg.ael <= wdata[2];
        cfg.ir  <= wdata[0];
        if (!wdata[5]) cfg.afh <= 1'b0;
        if (!wdata[4]) cfg.afl <= 1'b0;
      end
      if (wr && addr == A_LO) cfg.lo <= wdata;
      if (wr && addr == A_HI) cfg.hi <= wdata;
      // conversion result wins over a same-cycle flag write
      if (cv_hit) begin
        cfg.afh <= hit_over;
        cfg.afl <= hit_under;
      end
    end
  end
endmodule

// File: rtl/chalm_rdmux.sv
module chalm_rdmux
  import chalm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 5
) (
  input  logic                addr_ok,
  input  logic [AW-1:0]       addr,
  input  chan_cfg_t [NCH-1:0] cfg,
  input  logic                por,
  output logic [DW-1:0]       rdata
);
  always_comb begin
    rdata = '0;
    if (addr_ok) begin
      for (int c = 0; c < NCH; c++) begin
        if (addr == AW'(CTL_BASE + 2*c))
          rdata = {cfg[c].oe, cfg[c].oc, 2'b00, cfg[c].rc};
        if (addr == AW'(CTL_BASE + 2*c + 1))
          rdata = {por, 1'b0, cfg[c].afh, cfg[c].afl, cfg[c].aeh, cfg[c].ael, 1'b0, cfg[c].ir};
        if (addr == AW'(THR_BASE + 2*c))
          rdata = cfg[c].lo;
        if (addr == AW'(THR_BASE + 2*c + 1))
          rdata = cfg[c].hi;
      end
    end
  end
endmodule

// File: rtl/chan_alarm_regs.sv
module chan_alarm_regs
  import chalm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 5,
  parameter int RW  = 16,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] rdata,
  input  logic          cv_valid,
  input  logic [CW-1:0] cv_chan,
  input  logic [RW-1:0] cv_result,
  output logic [NCH-1:0] od_sink,
  output logic          csearch
);
  chan_cfg_t [NCH-1:0] cfg;
  logic                por_q;
  logic [DW-1:0]       rd_next;
  logic [NCH-1:0]      alarm_on;
  logic                ctl1_wr;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chalm_chan #(.RW(RW), .AW(AW), .CH(c)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .wr        (bus_wr),
      .addr      (bus_addr),
      .wdata     (bus_wdata),
      .cv_hit    (cv_valid && cv_chan == CW'(c)),
      .cv_result (cv_result),
      .cfg       (cfg[c])
    );
    assign alarm_on[c] = (cfg[c].afh && cfg[c].aeh) || (cfg[c].afl && cfg[c].ael);
  end

  chalm_rdmux #(.NCH(NCH), .AW(AW)) u_rd (
    .addr_ok (1'b1),
    .addr    (bus_addr),
    .cfg     (cfg),
    .por     (por_q),
    .rdata   (rd_next)
  );

  always_comb begin
    ctl1_wr = 1'b0;
    for (int c = 0; c < NCH; c++)
      if (bus_wr && bus_addr == AW'(CTL_BASE + 2*c + 1)) ctl1_wr = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      por_q   <= 1'b1;
      rdata   <= '0;
      csearch <= 1'b1;
      od_sink <= '0;
    end else begin
      if (ctl1_wr) por_q <= bus_wdata[7];
      rdata   <= rd_next;
      csearch <= por_q || (|alarm_on);
      for (int c = 0; c < NCH; c++)
        od_sink[c] <= cfg[c].oe && !cfg[c].oc;
    end
  end
endmodule

// File: rtl/chalm_chk.sv
module chalm_chk #(
  parameter int NCH = 4,
  parameter int AW  = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           bus_wr,
  input logic [AW-1:0]  bus_addr,
  input logic [7:0]     bus_wdata,
  input logic [7:0]     rdata,
  input logic [NCH-1:0] od_sink,
  input logic           csearch,
  input logic           por
);
  localparam logic [AW-1:0] CTL_LO = AW'(8);
  localparam logic [AW-1:0] CTL_HI = AW'(8 + 2*NCH);

  logic in_ctl;
  assign in_ctl = (bus_addr >= CTL_LO) && (bus_addr < CTL_HI);

  // R1
  reset_dflt_chk: assert property (@(posedge clk)
    rst |=> (csearch && od_sink == '0));

  // R3
  ctl0_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_ctl && !bus_addr[0]) |=> rdata[5:4] == 2'b00);

  // R4
  ctl1_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_ctl && bus_addr[0]) |=> (!rdata[6] && !rdata[1]));

  // R11
  sink_on_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == CTL_LO && bus_wdata[7:6] == 2'b10) |=> ##1 od_sink[0]);

  // R9
  search_por_chk: assert property (@(posedge clk) disable iff (rst)
    !csearch |-> !$past(por));
endmodule

bind chan_alarm_regs chalm_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .rdata     (rdata),
  .od_sink   (od_sink),
  .csearch   (csearch),
  .por       (por_q)
);

// File: tb/test_chan_alarm_regs.sv
`timescale 1ns/1ps
module test_chan_alarm_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  rdata;
  logic        cv_valid = 1'b0;
  logic [1:0]  cv_chan = '0;
  logic [15:0] cv_result = '0;
  logic [3:0]  od_sink;
  logic        csearch;

  always #5 clk = ~clk;

  chan_alarm_regs i_chan_alarm_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rdata(rdata), .cv_valid(cv_valid),
    .cv_chan(cv_chan), .cv_result(cv_result), .od_sink(od_sink),
    .csearch(csearch)
  );

  int total = 0, bad = 0;
  bit cmp_on = 0;

  // reference model: byte images of each register
  byte unsigned m_c0[4], m_c1[4], m_lo[4], m_hi[4];
  bit           m_por;
  byte unsigned m_rdata;
  bit           m_cs;
  bit [3:0]     m_sink;

  function automatic byte unsigned mread(int a);
    if (a >= 8 && a < 16)
      return (a % 2 == 0) ? m_c0[(a-8)/2] : ((m_c1[(a-8)/2] & 8'h7F) | (m_por ? 8'h80 : 8'h00));
    if (a >= 16 && a < 24)
      return (a % 2 == 0) ? m_lo[(a-16)/2] : m_hi[(a-16)/2];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 4; c++) begin
        m_c0[c] = 8'h08; m_c1[c] = 8'h0C; m_lo[c] = 8'h00; m_hi[c] = 8'hFF;
      end
      m_por = 1; m_rdata = 0; m_cs = 1; m_sink = 0;
    end else begin
      int a;
      m_rdata = mread(int'(bus_addr));
      m_cs = m_por;
      for (int c = 0; c < 4; c++) begin
        if ((m_c1[c][5] && m_c1[c][3]) || (m_c1[c][4] && m_c1[c][2])) m_cs = 1;
        m_sink[c] = m_c0[c][7] && !m_c0[c][6];
      end
      a = int'(bus_addr);
      if (bus_wr) begin
        if (a >= 8 && a < 16) begin
          if (a % 2 == 0) m_c0[(a-8)/2] = bus_wdata & 8'hCF;
          else begin
            m_c1[(a-8)/2] = (bus_wdata & 8'h0D) | (m_c1[(a-8)/2] & bus_wdata & 8'h30);
            m_por = bus_wdata[7];
          end
        end else if (a >= 16 && a < 24) begin
          if (a % 2 == 0) m_lo[(a-16)/2] = bus_wdata;
          else m_hi[(a-16)/2] = bus_wdata;
        end
      end
      if (cv_valid) begin
        int c, nb, mk, t, l, h;
        c  = int'(cv_chan);
        nb = (m_c0[c] % 16 == 0) ? 16 : m_c0[c] % 16;
        mk = (nb >= 8) ? 255 : ((255 << (8 - nb)) & 255);
        t  = (int'(cv_result) / 256) & mk;
        l  = m_lo[c] & mk;
        h  = m_hi[c] & mk;
        m_c1[c] = (m_c1[c] & 8'hCF) | ((t > h) ? 8'h20 : 8'h00) | ((t < l) ? 8'h10 : 8'h00);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R2 rdata vs model", rdata, m_rdata);
      chk("R9 csearch vs model", csearch, m_cs);
      chk("R11 od_sink vs model", od_sink, m_sink);
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_wr = 1; bus_addr = 5'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic conv(int ch, int r);
    @(negedge clk);
    cv_valid = 1; cv_chan = 2'(ch); cv_result = 16'(r);
    @(negedge clk);
    cv_valid = 0;
  endtask

  task automatic rd(int a, int exp, string tag);
    @(negedge clk);
    bus_addr = 5'(a);
    @(negedge clk);
    chk(tag, rdata, 32'(exp));
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cmp_on = 1;
    @(negedge clk);
    chk("R1 csearch after reset", csearch, 1);
    chk("R1 od_sink after reset", od_sink, 0);
    for (int c = 0; c < 4; c++) begin
      rd(8 + 2*c, 8'h08, "R1 ctrl0 default");
      rd(9 + 2*c, 8'h8C, "R1 ctrl1 default");
      rd(16 + 2*c, 8'h00, "R1 low limit default");
      rd(17 + 2*c, 8'hFF, "R1 high limit default");
    end
    rd(0, 0, "R2 unmapped low read");
    rd(31, 0, "R2 unmapped high read");

    // fixed-zero bits and flag writes of 1 ignored
    wr(8'h0A, 8'hFF);  rd(8'h0A, 8'hCF, "R3 ctrl0 fixed bits");
    wr(8'h0B, 8'hFF);  rd(8'h0B, 8'h8D, "R4 R7 ctrl1 fixed bits and flag set ignored");
    wr(8'h05, 8'hAA);  rd(8'h05, 0, "R2 unmapped write ignored");

    // thresholds on channel 0, clear marker
    wr(8'h10, 8'h40); wr(8'h11, 8'hC0);
    wr(8'h09, 8'h0C);
    @(negedge clk);
    chk("R10 R9 csearch after marker cleared", csearch, 0);

    conv(0, 16'hD000); rd(8'h09, 8'h2C, "R5 over flag");
    chk("R9 csearch with enabled over flag", csearch, 1);
    conv(0, 16'h8000); rd(8'h09, 8'h0C, "R7 in-range clears");
    @(negedge clk);
    chk("R9 csearch drops", csearch, 0);
    conv(0, 16'h3000); rd(8'h09, 8'h1C, "R5 under flag");
    wr(8'h09, 8'h0C);  rd(8'h09, 8'h0C, "R7 software clear");

    // reduced resolution on channel 2
    wr(8'h0C, 8'h03); wr(8'h14, 8'h3F); wr(8'h15, 8'hA0);
    conv(2, 16'h2100); rd(8'h0D, 8'h0C, "R6 masked low compare");
    conv(2, 16'hBF00); rd(8'h0D, 8'h0C, "R6 masked high compare");
    conv(2, 16'hC000); rd(8'h0D, 8'h2C, "R6 over at 3 bits");
    wr(8'h0D, 8'h0C);
    // code 0 = 16 bits on channel 3
    wr(8'h0E, 8'h00); wr(8'h16, 8'h01);
    conv(3, 16'h00FF); rd(8'h0F, 8'h1C, "R6 code 0 full width");

    // same-cycle write and conversion
    @(negedge clk);
    bus_wr = 1; bus_addr = 5'h09; bus_wdata = 8'h0C;
    cv_valid = 1; cv_chan = 0; cv_result = 16'hD000;
    @(negedge clk);
    bus_wr = 0; cv_valid = 0;
    rd(8'h09, 8'h2C, "R8 conversion wins");

    // shared marker
    wr(8'h0F, 8'h8C);
    rd(8'h09, 8'hAC, "R10 marker seen on channel 0");
    rd(8'h10, 8'h40, "R10 setting marker keeps limits");
    chk("R9 csearch with marker", csearch, 1);

    // open-drain control on channel 1
    wr(8'h0A, 8'h80); @(negedge clk);
    chk("R11 sink on", od_sink, 4'b0010);
    wr(8'h0A, 8'hC0); @(negedge clk);
    chk("R11 sink off level high", od_sink, 4'b0000);
    wr(8'h0A, 8'h40); @(negedge clk);
    chk("R11 sink off when disabled", od_sink, 4'b0000);

    // reset restores defaults
    @(negedge clk); rst = 1; cmp_on = 0;
    @(negedge clk); rst = 0; cmp_on = 1;
    rd(8'h0A, 8'h08, "R1 ctrl0 restored");
    rd(8'h10, 8'h00, "R1 low limit restored");
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule